// File: doc/BRIEF.md
# Interrupt Routing Controller Register Front End

This block holds the software-visible registers of an I/O interrupt routing controller with a parameterised number of pins (32 by default). Software does not address the registers directly. It writes a register number into a selector register at bus offset 0x00, then reads or writes the chosen register through a data window at bus offset 0x10. The selectable registers are an identification register, a read-only version register, an arbitration register that mirrors the identification value, and a 64-bit routing entry per pin, reached as two 32-bit halves.

The routing entries are exported as one flat vector to the delivery logic. A one-cycle strobe for each entry tells that logic when software has changed the entry. Two bits of every entry report delivery state: bit 12 is the in-flight flag and bit 14 is the awaiting-end-of-interrupt flag. Software cannot write these bits. The delivery logic sets or clears them through a per-pin status load port.

Bus transfers are single-cycle requests carrying a size code in bytes. Any request that is not a 4-byte transfer at one of the two defined offsets has no effect. The read data is registered.

Top module: `irq_route_regs`

## Requirements
- R1: After reset every routing entry equals 0x0001000000010000, so that bits 16 and 48 are set and every pin is masked. The selector register, the identification field and `bus_rdata` all reset to zero.
- R2: A write takes effect only when `bus_size` is 4 and `bus_offset` is 0x00 or 0x10; any other write changes no register. A read with any other size or offset returns zero.
- R3: The selector register at offset 0x00 stores and reads back all 32 bits. Window accesses decode only the selector's bits 7:0 as the register number.
- R4: Register number 0x00 is the identification register. A write keeps only data bits 27:24, and a read returns those four bits in place with all other bits zero. Register number 0x02 reads the same value.
- R5: Register number 0x01 reads (NUM_PINS-1) shifted left by 16, ORed with 0x11, which is 0x001F0011 by default. Writes to register numbers 0x01 and 0x02 change nothing.
- R6: Pin p owns register numbers 0x10+2p, which holds entry bits 31:0, and 0x11+2p, which holds bits 63:32. A write replaces only the addressed half, and a read returns that half.
- R7: Software writes never change entry bits 12 and 14. When `stat_load[p]` is high, pin p's bit 14 takes `stat_remote_irr[p]` and its bit 12 takes `stat_deliv_busy[p]` on the next clock edge.
- R8: A window read of any register number other than 0x00, 0x01, 0x02 and the routing range returns zero.
- R9: Read data appears on `bus_rdata` in the cycle after the read is presented. It holds until the next read request.
- R10: `tbl_wr_strobe[p]` is high for exactly one cycle, the one after a legal window write to either half of pin p. At most one strobe bit is high at a time.
- R11: `tbl_entries[64p+63:64p]` always shows pin p's current 64-bit entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 8 | Byte offset of the request |
| bus_size | input | 3 | Transfer size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| stat_load | input | NUM_PINS | Load the delivery-state bits of each pin |
| stat_remote_irr | input | NUM_PINS | New value of entry bit 14 per pin |
| stat_deliv_busy | input | NUM_PINS | New value of entry bit 12 per pin |
| tbl_entries | output | 64*NUM_PINS | All routing entries, pin p at bits 64p+63:64p |
| tbl_wr_strobe | output | NUM_PINS | One-cycle pulse after software writes pin p |

## Verification
A wrong selector decode sends a write to the wrong pin. This shows on the very next cycle, because the strobe bit and the slice of `tbl_entries` change for a pin other than the one addressed. A corrupted read-only mask lets a software write flip bit 12 or 14, which is visible on the exported entry one edge later. A stale read-mux input, or a missing zero default, shows up in the read that follows the request, so a sweep over all 256 register numbers exposes any mis-decoded register number within one read.

// File: rtl/irq_route_pkg.sv
// Shared constants and types for the interrupt routing register front end.
// Assumes the 64-bit entry layout used by the delivery logic, in which the
// in-flight flag is at bit 12 and the awaiting-EOI flag is at bit 14.
package irq_route_pkg;
    localparam int ENT_W      = 64;
    localparam int HALF_W     = 32;
    localparam int BIT_DLV    = 12;
    localparam int BIT_RIRR   = 14;
    localparam int ID_LSB     = 24;
    localparam int ID_W       = 4;
    localparam int MAXRED_LSB = 16;

    localparam logic [ENT_W-1:0] ENT_RST = 64'h0001_0000_0001_0000;

    localparam logic [7:0] REG_ID  = 8'h00;
    localparam logic [7:0] REG_VER = 8'h01;
    localparam logic [7:0] REG_ARB = 8'h02;
    localparam logic [7:0] REG_TBL = 8'h10;

    localparam logic [7:0] OFF_SEL   = 8'h00;
    localparam logic [7:0] OFF_WIN   = 8'h10;
    localparam logic [2:0] SIZE_WORD = 3'd4;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_TBL
    } tgt_e;
endpackage

// File: rtl/irq_route_decode.sv
// Bus request and register-number decoder.
// Purely combinational. It qualifies the request by size and offset and
// classifies the selected register number. Assumes NUM_PINS <= 120, so that
// the routing range fits within 8-bit register numbers.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 32,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [7:0]       bus_offset,
    input  logic [2:0]       bus_size,
    input  logic [7:0]       reg_num,
    output logic             idx_wr,
    output logic             idx_rd,
    output logic             win_wr,
    output logic             win_rd,
    output tgt_e             tgt,
    output logic [PIN_W-1:0] pin,
    output logic             hi_half
);
    localparam logic [8:0] TBL_END = 9'(REG_TBL) + 9'(2 * NUM_PINS);

    logic       legal;
    logic [7:0] rel;

    // Qualify the request: a 4-byte access at one of the two offsets.
    always_comb begin
        legal  = bus_valid && (bus_size == SIZE_WORD);
        idx_wr = legal && (bus_offset == OFF_SEL) && bus_write;
        idx_rd = legal && (bus_offset == OFF_SEL) && !bus_write;
        win_wr = legal && (bus_offset == OFF_WIN) && bus_write;
        win_rd = legal && (bus_offset == OFF_WIN) && !bus_write;
    end

    // Classify the register number and split table numbers into pin and half.
    always_comb begin
        rel     = reg_num - REG_TBL;
        pin     = rel[PIN_W:1];
        hi_half = rel[0];
        if (reg_num == REG_ID)
            tgt = TGT_ID;
        else if (reg_num == REG_VER)
            tgt = TGT_VER;
        else if (reg_num == REG_ARB)
            tgt = TGT_ARB;
        else if (reg_num >= REG_TBL && {1'b0, reg_num} < TBL_END)
            tgt = TGT_TBL;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/irq_route_entry.sv
// One 64-bit routing entry with protected delivery-state bits.
// Software writes replace one 32-bit half but never bits 12 and 14. The
// status load port owns those two bits and wins over any software write.
// Registers a one-cycle strobe for every software write.
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic              stat_ld,
    input  logic              stat_rirr,
    input  logic              stat_dlv,
    output logic [ENT_W-1:0]  entry,
    output logic              strobe
);
    logic [ENT_W-1:0] nxt;

    // Merge the software half write, restore the protected bits, then apply status.
    always_comb begin
        nxt = entry;
        if (wr_en) begin
            if (wr_hi)
                nxt[ENT_W-1:HALF_W] = wdata;
            else
                nxt[HALF_W-1:0] = wdata;
            nxt[BIT_DLV]  = entry[BIT_DLV];
            nxt[BIT_RIRR] = entry[BIT_RIRR];
        end
        if (stat_ld) begin
            nxt[BIT_DLV]  = stat_dlv;
            nxt[BIT_RIRR] = stat_rirr;
        end
    end

    // Entry storage and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry  <= ENT_RST;
            strobe <= 1'b0;
        end else begin
            entry  <= nxt;
            strobe <= wr_en;
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
// Top of the interrupt routing register front end.
// Holds the selector and identification registers and one routing entry per
// pin, and returns registered read data one cycle after a read request.
// Assumes single-cycle bus requests with no back-pressure.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [7:0]                bus_offset,
    input  logic [2:0]                bus_size,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PINS-1:0]       stat_load,
    input  logic [NUM_PINS-1:0]       stat_remote_irr,
    input  logic [NUM_PINS-1:0]       stat_deliv_busy,
    output logic [ENT_W*NUM_PINS-1:0] tbl_entries,
    output logic [NUM_PINS-1:0]       tbl_wr_strobe
);
    localparam int PIN_W = $clog2(NUM_PINS);
    localparam logic [31:0] VER_VAL = (32'(NUM_PINS - 1) << MAXRED_LSB) | 32'h11;

    logic [31:0]      index_q;
    logic [ID_W-1:0]  id_q;
    logic [31:0]      id_word;
    logic [31:0]      win_val;
    logic [31:0]      rd_next;
    logic [ENT_W-1:0] ent [NUM_PINS];

    logic             idx_wr, idx_rd, win_wr, win_rd, hi_half;
    tgt_e             tgt;
    logic [PIN_W-1:0] pin;

    irq_route_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_offset(bus_offset),
        .bus_size  (bus_size),
        .reg_num   (index_q[7:0]),
        .idx_wr    (idx_wr),
        .idx_rd    (idx_rd),
        .win_wr    (win_wr),
        .win_rd    (win_rd),
        .tgt       (tgt),
        .pin       (pin),
        .hi_half   (hi_half)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic wr_this;
        assign wr_this = win_wr && (tgt == TGT_TBL) && (pin == PIN_W'(p));
        irq_route_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_this),
            .wr_hi    (hi_half),
            .wdata    (bus_wdata),
            .stat_ld  (stat_load[p]),
            .stat_rirr(stat_remote_irr[p]),
            .stat_dlv (stat_deliv_busy[p]),
            .entry    (ent[p]),
            .strobe   (tbl_wr_strobe[p])
        );
        assign tbl_entries[p*ENT_W +: ENT_W] = ent[p];
    end

    // Selector register and identification field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
            id_q    <= '0;
        end else begin
            if (idx_wr)
                index_q <= bus_wdata;
            if (win_wr && tgt == TGT_ID)
                id_q <= bus_wdata[ID_LSB +: ID_W];
        end
    end

    // Window read multiplexer.
    always_comb begin
        id_word = '0;
        id_word[ID_LSB +: ID_W] = id_q;
        case (tgt)
            TGT_ID, TGT_ARB: win_val = id_word;
            TGT_VER:         win_val = VER_VAL;
            TGT_TBL:         win_val = hi_half ? ent[pin][ENT_W-1:HALF_W] : ent[pin][HALF_W-1:0];
            default:         win_val = '0;
        endcase
        if (idx_rd)
            rd_next = index_q;
        else if (win_rd)
            rd_next = win_val;
        else
            rd_next = '0;
    end

    // Registered read data, updated on every read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_valid && !bus_write)
            bus_rdata <= rd_next;
    end
endmodule

// File: rtl/irq_route_regs_chk.sv
// Checker for irq_route_regs, bound to every instance of the top module.
// It observes only the ports of the top module.
module irq_route_regs_chk #(
    parameter int NUM_PINS = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_valid,
    input logic                   bus_write,
    input logic [7:0]             bus_offset,
    input logic [2:0]             bus_size,
    input logic [31:0]            bus_rdata,
    input logic [NUM_PINS-1:0]    stat_load,
    input logic [64*NUM_PINS-1:0] tbl_entries,
    input logic [NUM_PINS-1:0]    tbl_wr_strobe
);
    logic legal_win_wr;
    logic illegal_rd;

    // Recompute the legal-access conditions from the ports.
    always_comb begin
        legal_win_wr = bus_valid && bus_write && bus_size == 3'd4 && bus_offset == 8'h10;
        illegal_rd   = bus_valid && !bus_write &&
                       !(bus_size == 3'd4 && (bus_offset == 8'h00 || bus_offset == 8'h10));
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ro
        assert_ro_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !stat_load[p] |=> $stable(tbl_entries[p*64+12]) && $stable(tbl_entries[p*64+14]));
    end

    assert_strobe_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|tbl_wr_strobe) |-> $past(legal_win_wr));

    assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tbl_wr_strobe));

    assert_bad_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_rd |=> bus_rdata == 32'h0);

    assert_table_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!legal_win_wr && stat_load == '0) |=> $stable(tbl_entries));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_offset   (bus_offset),
    .bus_size     (bus_size),
    .bus_rdata    (bus_rdata),
    .stat_load    (stat_load),
    .tbl_entries  (tbl_entries),
    .tbl_wr_strobe(tbl_wr_strobe)
);

// File: tb/test_irq_route_regs.sv
// Self-checking bench for irq_route_regs. It sweeps every pin and every
// register number against a model computed from the requirements.
module test_irq_route_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [7:0]      bus_offset = '0;
    logic [2:0]      bus_size = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   stat_load = '0;
    logic [NP-1:0]   stat_remote_irr = '0;
    logic [NP-1:0]   stat_deliv_busy = '0;
    logic [64*NP-1:0] tbl_entries;
    logic [NP-1:0]   tbl_wr_strobe;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [63:0] exp_tbl [NP];
    logic [3:0]  exp_id;
    logic [31:0] rd;

    irq_route_regs #(.NUM_PINS(NP)) i_irq_route_regs (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_offset = off; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] off, input logic [2:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_offset = off; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_read(input int r);
        if (r == 0 || r == 2) return {4'h0, exp_id, 24'h0};
        if (r == 1) return (32'(NP - 1) << 16) | 32'h11;
        if (r >= 16 && r < 16 + 2 * NP)
            return (r % 2) ? exp_tbl[(r - 16) / 2][63:32] : exp_tbl[(r - 16) / 2][31:0];
        return 32'h0;
    endfunction

    task automatic chk_table(input string req);
        for (int p = 0; p < NP; p++)
            chk(req, tbl_entries[p*64 +: 64], exp_tbl[p]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) exp_tbl[p] = 64'h0001_0000_0001_0000;
        exp_id = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk("R1 rdata", 64'(bus_rdata), 64'h0);
        chk_table("R1 entries");
        bus_rd(8'h00, 3'd4, rd); chk("R1 selector", 64'(rd), 64'h0);
        bus_rd(8'h10, 3'd4, rd); chk("R1 id", 64'(rd), 64'h0);

        // R5: version value and write protection
        bus_wr(8'h00, 3'd4, 32'h1);
        bus_rd(8'h10, 3'd4, rd); chk("R5 version", 64'(rd), 64'h001F0011);
        bus_wr(8'h10, 3'd4, 32'hFFFF_FFFF);
        bus_rd(8'h10, 3'd4, rd); chk("R5 version write ignored", 64'(rd), 64'h001F0011);
        bus_wr(8'h00, 3'd4, 32'h2);
        bus_wr(8'h10, 3'd4, 32'hFFFF_FFFF);
        bus_rd(8'h10, 3'd4, rd); chk("R5 arb write ignored", 64'(rd), 64'h0);
        bus_wr(8'h00, 3'd4, 32'h0);
        bus_rd(8'h10, 3'd4, rd); chk("R5 id untouched by arb write", 64'(rd), 64'h0);

        // R4: identification field only
        bus_wr(8'h00, 3'd4, 32'h0);
        bus_wr(8'h10, 3'd4, 32'hABCD_EF12);
        exp_id = 4'hB;
        bus_rd(8'h10, 3'd4, rd); chk("R4 id", 64'(rd), 64'h0B00_0000);
        bus_wr(8'h00, 3'd4, 32'h2);
        bus_rd(8'h10, 3'd4, rd); chk("R4 arb mirrors id", 64'(rd), 64'h0B00_0000);

        // R3: selector keeps 32 bits, decode uses bits 7:0
        bus_wr(8'h00, 3'd4, 32'h1234_5601);
        bus_rd(8'h00, 3'd4, rd); chk("R3 selector readback", 64'(rd), 64'h1234_5601);
        bus_rd(8'h10, 3'd4, rd); chk("R3 low byte decode", 64'(rd), 64'h001F0011);

        // R6, R10, R11: write every pin, both halves
        for (int p = 0; p < NP; p++) begin
            logic [31:0] lo, hi;
            lo = 32'hA5A5_7000 ^ (32'(p) * 32'h0101_0101);
            hi = 32'h5A5A_5A5A ^ (32'(p) << 8);
            bus_wr(8'h00, 3'd4, 32'(16 + 2 * p));
            bus_wr(8'h10, 3'd4, lo);
            chk("R10 strobe lo", 64'(tbl_wr_strobe), 64'(32'h1 << p));
            bus_wr(8'h00, 3'd4, 32'(17 + 2 * p));
            bus_wr(8'h10, 3'd4, hi);
            chk("R10 strobe hi", 64'(tbl_wr_strobe), 64'(32'h1 << p));
            exp_tbl[p] = {hi, lo & ~32'h0000_5000};
            chk("R11 entry export", tbl_entries[p*64 +: 64], exp_tbl[p]);
        end
        @(negedge clk);
        chk("R10 strobe one cycle", 64'(tbl_wr_strobe), 64'h0);

        // R6: a half write leaves the other half alone
        bus_wr(8'h00, 3'd4, 32'(17 + 2 * 9));
        bus_wr(8'h10, 3'd4, 32'hDEAD_BEEF);
        exp_tbl[9][63:32] = 32'hDEAD_BEEF;
        chk("R6 hi only", tbl_entries[9*64 +: 64], exp_tbl[9]);

        // R7: status port owns bits 12 and 14
        @(negedge clk);
        stat_load = '0; stat_load[3] = 1'b1; stat_load[7] = 1'b1;
        stat_remote_irr[3] = 1'b1; stat_deliv_busy[3] = 1'b1;
        stat_remote_irr[7] = 1'b1; stat_deliv_busy[7] = 1'b0;
        @(negedge clk);
        stat_load = '0;
        exp_tbl[3][14] = 1'b1; exp_tbl[3][12] = 1'b1;
        exp_tbl[7][14] = 1'b1; exp_tbl[7][12] = 1'b0;
        chk("R7 status load pin3", tbl_entries[3*64 +: 64], exp_tbl[3]);
        chk("R7 status load pin7", tbl_entries[7*64 +: 64], exp_tbl[7]);
        bus_wr(8'h00, 3'd4, 32'(16 + 2 * 3));
        bus_wr(8'h10, 3'd4, 32'h0000_0000);
        exp_tbl[3][31:0] = 32'h0000_5000;
        bus_rd(8'h10, 3'd4, rd); chk("R7 bits kept on clear write", 64'(rd), 64'h0000_5000);
        bus_wr(8'h00, 3'd4, 32'(16 + 2 * 4));
        bus_wr(8'h10, 3'd4, 32'hFFFF_FFFF);
        exp_tbl[4][31:0] = 32'hFFFF_AFFF;
        bus_rd(8'h10, 3'd4, rd); chk("R7 bits kept on set write", 64'(rd), 64'hFFFF_AFFF);

        // R2: illegal sizes and offsets
        bus_wr(8'h00, 3'd4, 32'(16 + 2 * 5));
        bus_wr(8'h10, 3'd2, 32'h1111_1111);
        bus_wr(8'h14, 3'd4, 32'h2222_2222);
        bus_wr(8'h10, 3'd1, 32'h3333_3333);
        chk_table("R2 illegal write ignored");
        bus_wr(8'h00, 3'd2, 32'h0000_0001);
        bus_rd(8'h00, 3'd4, rd); chk("R2 selector kept", 64'(rd), 64'(16 + 2 * 5));
        bus_rd(8'h04, 3'd4, rd); chk("R2 bad offset read", 64'(rd), 64'h0);
        bus_rd(8'h10, 3'd1, rd); chk("R2 bad size read", 64'(rd), 64'h0);
        bus_rd(8'h00, 3'd8, rd); chk("R2 bad size selector", 64'(rd), 64'h0);

        // R9: read latency and hold
        bus_wr(8'h00, 3'd4, 32'h1);
        bus_rd(8'h10, 3'd4, rd); chk("R9 one-cycle read", 64'(rd), 64'h001F0011);
        repeat (3) @(negedge clk);
        chk("R9 hold", 64'(bus_rdata), 64'h001F0011);

        // R8, R6: sweep every register number
        for (int r = 0; r < 256; r++) begin
            bus_wr(8'h00, 3'd4, 32'(r));
            bus_rd(8'h10, 3'd4, rd);
            chk((r >= 16 && r < 16 + 2 * NP) ? "R6 sweep" : "R8 sweep", 64'(rd), 64'(exp_read(r)));
        end
        chk_table("R11 final table");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule